// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block lets software reach the management registers of external Ethernet PHYs over a two-wire MDC/MDIO bus. Software starts a transaction with one 32-bit write to a command register. That word carries the operation, the PHY address, the PHY register number and, for writes, the 16-bit payload. The block then produces the serial clock MDC from the system clock and shifts out a complete Clause-22 frame. On a read it releases MDIO for the turnaround and shifts the PHY's answer back in.

The command register also serves as the status register. It shows a busy flag, a flag that says whether a finished read got an answer, and the 16-bit data field. Completion is also reported through an interrupt. A cause register holds a done bit, which software clears by writing zero to it. A mask register selects which causes drive the interrupt line.

The register port is a plain write strobe with byte addresses. Read data is a combinational function of the address.

Top module: `mgmt_c22_master`

## Requirements
- R1: The register at byte offset 0x00 reads as: data in [15:0], PHY address in [20:16], register number in [25:21], operation in bit 26 (1 = read, 0 = write), read-valid in bit 27, busy in bit 28, and zero in [31:29]. A write to it loads the operation, address, register and data fields.
- R2: A write to offset 0x00 while busy is clear is accepted on that clock edge. Busy reads 1 from the next cycle for exactly 128*MDC_HALF cycles, which is 64 MDC periods.
- R3: Each frame is 32 ones, then start 01, then opcode 10 (read) or 01 (write), then the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits, all MSB first. Writes drive the turnaround as 10. MDC has a period of 2*MDC_HALF clocks and is low with MDIO released while idle. MDIO changes only while MDC is low.
- R4: During a read, MDIO is released from the first turnaround bit to the end of the frame. Data is sampled on the rising edges of MDC and appears in bits [15:0] when busy falls.
- R5: Read-valid is cleared when a command is accepted. When a read completes, it is set only if the PHY drove 0 in the second turnaround bit. A write leaves it at 0.
- R6: A command write that arrives while busy is set has no effect on the frame in flight or on the register fields.
- R7: Bit 4 of the cause register at offset 0x7C is set on the edge where busy falls. All other cause bits read 0.
- R8: A write to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. If a clear and a completion fall on the same edge, the completion wins.
- R9: Bit 4 of the mask register at offset 0x80 is writable and readable, and other bits read 0. The interrupt output is high while both the done cause and its mask bit are set.
- R10: After reset, all three registers read 0, and MDC, the MDIO enable and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check the following on every cycle:
- Acceptance raises busy and clears read-valid.
- The latched command stays fixed while busy.
- MDC stays low and MDIO stays released while idle.
- MDIO never moves while MDC is high.
- The fall of busy sets the done cause and, when masked in, the interrupt.

The bench scenarios show the rest, using a behavioural PHY:
- the exact bit pattern of each frame and the length of the preamble,
- the busy duration,
- read data and the read-valid outcome for answering and silent addresses,
- the clear-by-zero cause semantics, including a clear that collides with completion.

// File: rtl/mgmt_c22_pkg.sv
package mgmt_c22_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_LAST    = 47;
    localparam int DATA_FIRST = 48;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef struct packed {
        logic        rd;
        logic [4:0]  regad;
        logic [4:0]  phyad;
        logic [15:0] data;
    } cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(cmd_t c);
        return {32'hFFFF_FFFF, 2'b01,
                c.rd ? OPC_READ : OPC_WRITE,
                c.phyad, c.regad,
                c.rd ? 2'b11 : 2'b10,
                c.rd ? 16'h0000 : c.data};
    endfunction

endpackage

// File: rtl/mgmt_c22_clkgen.sv
module mgmt_c22_clkgen #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    assign wrap = (g_q.cnt == CW'(HALF - 1));

    always_comb begin
        g_d  = g_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!run) begin
            g_d = '0;
        end else if (wrap) begin
            g_d.cnt = '0;
            g_d.mdc = ~g_q.mdc;
            rise    = ~g_q.mdc;
            fall    = g_q.mdc;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mdc = g_q.mdc;

endmodule

// File: rtl/mgmt_c22_shifter.sv
module mgmt_c22_shifter
    import mgmt_c22_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cmd_t        cmd,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        active,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rx_data,
    output logic        ta_ok
);
    localparam int IW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IW-1:0]         idx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rx;
        logic                  ta_ok;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.rd     = cmd.rd;
                s_d.idx    = '0;
                s_d.sh     = build_frame(cmd);
                s_d.rx     = '0;
                s_d.ta_ok  = 1'b0;
            end
        end else if (rise) begin
            if (s_q.rd && s_q.idx == IW'(TA_LAST))
                s_d.ta_ok = ~mdio_i;
            if (s_q.rd && s_q.idx >= IW'(DATA_FIRST))
                s_d.rx = {s_q.rx[14:0], mdio_i};
        end else if (fall) begin
            if (s_q.idx == IW'(FRAME_BITS - 1)) begin
                s_d.active = 1'b0;
                done       = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
                s_d.sh  = {s_q.sh[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.active;
    assign mdio_o  = s_q.active & s_q.sh[FRAME_BITS-1];
    assign mdio_oe = s_q.active & ~(s_q.rd && s_q.idx >= IW'(TA_FIRST));
    assign rx_data = s_q.rx;
    assign ta_ok   = s_q.ta_ok;

endmodule

// File: rtl/mgmt_c22_master.sv
module mgmt_c22_master
    import mgmt_c22_pkg::*;
#(
    parameter int MDC_HALF = 10,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFF_CMD   = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_CAUSE = ADDR_W'(8'h7C);
    localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(8'h80);
    localparam int                DONE_BIT  = 4;

    typedef struct packed {
        logic busy;
        logic valid;
        cmd_t cmd;
        logic cause;
        logic mask;
    } regs_t;

    regs_t r_d, r_q;

    logic        accept, run, rise, fall, done, ta_ok, shf_active;
    logic [15:0] rx_data;
    cmd_t        new_cmd;

    // Named views of register state for the bound checker.
    logic        st_busy, st_valid, st_cause, st_mask;
    logic [10:0] st_hdr;
    logic        unused_wdata;

    assign new_cmd = '{rd: reg_wdata[26], regad: reg_wdata[25:21],
                       phyad: reg_wdata[20:16], data: reg_wdata[15:0]};
    assign accept  = reg_we && (reg_addr == OFF_CMD) && !r_q.busy;
    assign run     = shf_active;

    mgmt_c22_clkgen #(.HALF(MDC_HALF)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mgmt_c22_shifter u_shifter (
        .clk(clk), .rst_n(rst_n), .start(accept), .cmd(new_cmd),
        .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .active(shf_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done(done), .rx_data(rx_data), .ta_ok(ta_ok)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.busy  = 1'b1;
            r_d.valid = 1'b0;
            r_d.cmd   = new_cmd;
        end
        if (done) begin
            r_d.busy  = 1'b0;
            r_d.valid = r_q.cmd.rd & ta_ok;
            if (r_q.cmd.rd) r_d.cmd.data = rx_data;
        end
        if (reg_we && reg_addr == OFF_CAUSE)
            r_d.cause = r_q.cause & reg_wdata[DONE_BIT];
        if (done)
            r_d.cause = 1'b1;
        if (reg_we && reg_addr == OFF_MASK)
            r_d.mask = reg_wdata[DONE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CMD)
            reg_rdata = {3'b000, r_q.busy, r_q.valid, r_q.cmd.rd,
                         r_q.cmd.regad, r_q.cmd.phyad, r_q.cmd.data};
        else if (reg_addr == OFF_CAUSE)
            reg_rdata[DONE_BIT] = r_q.cause;
        else if (reg_addr == OFF_MASK)
            reg_rdata[DONE_BIT] = r_q.mask;
    end

    assign irq          = r_q.cause & r_q.mask;
    assign st_busy      = r_q.busy;
    assign st_valid     = r_q.valid;
    assign st_cause     = r_q.cause;
    assign st_mask      = r_q.mask;
    assign st_hdr       = {r_q.cmd.rd, r_q.cmd.regad, r_q.cmd.phyad};
    assign unused_wdata = ^{reg_wdata[31:27], reg_wdata[3:0]};

endmodule

// File: rtl/mgmt_c22_checker.sv
module mgmt_c22_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              busy,
    input logic              valid,
    input logic              cause,
    input logic              mask,
    input logic [10:0]       hdr,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              irq
);
    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == '0) && !busy;

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> busy);

    p_valid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !valid);

    p_hold_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(hdr));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_mdio_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cause);

    p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && mask) |-> irq);

endmodule

bind mgmt_c22_master mgmt_c22_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .busy(st_busy), .valid(st_valid), .cause(st_cause), .mask(st_mask),
    .hdr(st_hdr), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
);

// File: tb/mgmt_c22_master_bench.sv
`timescale 1ns/1ps
module mgmt_c22_master_bench;
    localparam int H      = 2;
    localparam int TXN    = 128 * H;
    localparam logic [4:0] PHY_ID = 5'h09;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, dut_o, dut_oe, irq, mdio_line;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    mgmt_c22_master #(.MDC_HALF(H), .ADDR_W(8)) u_mgmt_c22_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(dut_o), .mdio_oe(dut_oe), .mdio_i(mdio_line), .irq(irq)
    );

    // ---------------- behavioural PHY ----------------
    logic [15:0] phy_mem [32];
    logic        phy_drv = 1'b0, phy_bit = 1'b1;
    int          ones = 0, pos = 0, last_ones = 0, nframes = 0;
    bit          inframe = 0, got0 = 0, rd_resp = 0, oe_in_ta = 0;
    logic [31:0] cap = '0, last_cap = '0;
    logic [1:0]  cur_op = '0;
    logic [4:0]  cur_phy = '0, cur_reg = '0;

    assign mdio_line = phy_drv ? phy_bit : (dut_oe ? dut_o : 1'b1);

    initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'hC3A0 ^ 16'(i);

    always @(posedge mdc) begin
        if (!inframe) begin
            if (got0) begin
                got0 = 0;
                if (mdio_line === 1'b1) begin
                    inframe = 1; pos = 34; cap = 32'b01; oe_in_ta = 0;
                end else ones = 0;
            end else if (mdio_line === 1'b1) ones++;
            else if (ones >= 32) begin got0 = 1; last_ones = ones; end
            else ones = 0;
        end else begin
            if (pos >= 46 && cur_op == 2'b10 && dut_oe) oe_in_ta = 1;
            cap = {cap[30:0], mdio_line};
            pos++;
            if (pos == 46) begin
                cur_op = cap[11:10]; cur_phy = cap[9:5]; cur_reg = cap[4:0];
                rd_resp = (cur_op == 2'b10) && (cur_phy == PHY_ID);
            end
            if (pos == 64) begin
                last_cap = cap; nframes++;
                if (cur_op == 2'b01 && cur_phy == PHY_ID) phy_mem[cur_reg] = cap[15:0];
                inframe = 0; ones = 0; rd_resp = 0;
            end
        end
    end

    always @(negedge mdc) begin
        if (inframe && rd_resp && pos >= 47) begin
            phy_drv = 1'b1;
            phy_bit = (pos == 47) ? 1'b0 : phy_mem[cur_reg][63-pos];
        end else begin
            phy_drv = 1'b0;
            phy_bit = 1'b1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #0.1; d = reg_rdata; reg_addr = 8'h00;
    endtask

    // Called at the negedge after the accept edge; counts busy cycles.
    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_addr = 8'h00; #0.1;
        while (reg_rdata[28] === 1'b1) begin
            cyc++;
            @(negedge clk); #0.1;
        end
    endtask

    function automatic logic [31:0] mkcmd(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
        return {5'b0, r, g, p, d};
    endfunction

    // {rd, phy, reg, data}
    localparam logic [26:0] VEC [7] = '{
        {1'b0, 5'h09, 5'h03, 16'hBEEF},
        {1'b1, 5'h09, 5'h03, 16'h0000},
        {1'b1, 5'h09, 5'h1F, 16'h0000},
        {1'b0, 5'h09, 5'h00, 16'h0001},
        {1'b1, 5'h1F, 5'h00, 16'h0000},
        {1'b1, 5'h09, 5'h00, 16'h0000},
        {1'b0, 5'h12, 5'h15, 16'h5A5A}
    };

    logic [15:0] exp_mem [32];
    logic [31:0] v;
    int          cyc, nf0;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) exp_mem[i] = 16'hC3A0 ^ 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(8'h00, v); chk("R10", "cmd reg", v, 32'h0);
        rd(8'h7C, v); chk("R10", "cause reg", v, 32'h0);
        rd(8'h80, v); chk("R10", "mask reg", v, 32'h0);
        chk("R10", "mdc/oe/irq", {29'b0, mdc, dut_oe, irq}, 32'h0);

        // table of transactions
        for (int k = 0; k < 7; k++) begin
            logic        r;
            logic [4:0]  p, g;
            logic [15:0] d;
            {r, p, g, d} = VEC[k];
            wr(8'h00, mkcmd(r, p, g, d));
            wait_idle(cyc);
            chk("R2", "busy cycles", 32'(cyc), 32'(TXN));
            chk("R3", "preamble ones", 32'(last_ones), 32'd32);
            chk("R3", "frame header", {18'b0, last_cap[31:18]},
                {18'b0, 2'b01, (r ? 2'b10 : 2'b01), p, g});
            rd(8'h00, v);
            chk("R1", "fields", {v[31:26], v[25:21], v[20:16]}, {3'b000, 1'b0, v[27], r, g, p});
            if (!r) begin
                chk("R3", "write ta+data", {14'b0, last_cap[17:0]}, {14'b0, 2'b10, d});
                chk("R5", "valid after write", {31'b0, v[27]}, 32'h0);
                chk("R1", "write data field", {16'b0, v[15:0]}, {16'b0, d});
                if (p == PHY_ID) exp_mem[g] = d;
            end else begin
                chk("R4", "oe released in ta/data", {31'b0, oe_in_ta}, 32'h0);
                if (p == PHY_ID) begin
                    chk("R5", "valid on answered read", {31'b0, v[27]}, 32'h1);
                    chk("R4", "read data", {16'b0, v[15:0]}, {16'b0, exp_mem[g]});
                end else
                    chk("R5", "valid on silent read", {31'b0, v[27]}, 32'h0);
            end
            rd(8'h7C, v); chk("R7", "done cause", v, 32'h10);
            chk("R9", "irq masked off", {31'b0, irq}, 32'h0);
            wr(8'h7C, 32'hFFFF_FFEF);
        end

        // R5: read-valid cleared on acceptance (previous read was answered)
        wr(8'h00, mkcmd(1'b1, PHY_ID, 5'h02, 16'h0));
        wait_idle(cyc);
        wr(8'h00, mkcmd(1'b0, PHY_ID, 5'h02, 16'h1234));
        rd(8'h00, v);
        chk("R5", "valid cleared on accept", {30'b0, v[28:27]}, 32'h2);
        wait_idle(cyc);
        wr(8'h7C, 32'h0);

        // R6: command during busy ignored
        nf0 = nframes;
        wr(8'h00, mkcmd(1'b0, PHY_ID, 5'h07, 16'h1111));
        repeat (10) @(negedge clk);
        wr(8'h00, mkcmd(1'b1, 5'h04, 5'h08, 16'h2222));
        wait_idle(cyc);
        chk("R6", "busy length unchanged", 32'(cyc), 32'(TXN - 12));
        repeat (300) @(negedge clk);
        chk("R6", "frame count", 32'(nframes - nf0), 32'd1);
        chk("R6", "frame content", last_cap, {2'b01, 2'b01, PHY_ID, 5'h07, 2'b10, 16'h1111});
        rd(8'h00, v);
        chk("R6", "register fields", v, {3'b0, 1'b0, 1'b0, 1'b0, 5'h07, PHY_ID, 16'h1111});

        // R7 / R8 cause semantics
        rd(8'h7C, v); chk("R7", "cause set", v, 32'h10);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, v); chk("R8", "write ones keeps", v, 32'h10);
        wr(8'h7C, 32'hFFFF_FFEF);
        rd(8'h7C, v); chk("R8", "write zero clears", v, 32'h0);

        // R9 mask and interrupt
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, v); chk("R9", "mask readback", v, 32'h10);
        chk("R9", "irq low, no cause", {31'b0, irq}, 32'h0);
        wr(8'h00, mkcmd(1'b0, PHY_ID, 5'h05, 16'h0F0F));
        wait_idle(cyc);
        chk("R9", "irq on done", {31'b0, irq}, 32'h1);
        wr(8'h80, 32'h0);
        chk("R9", "irq masked", {31'b0, irq}, 32'h0);
        wr(8'h7C, 32'h0);

        // R8 completion wins over simultaneous clear
        wr(8'h00, mkcmd(1'b0, PHY_ID, 5'h06, 16'hA5A5));
        repeat (TXN - 1) @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h7C; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h00;
        rd(8'h00, v); chk("R8", "busy dropped at collision", {31'b0, v[28]}, 32'h0);
        rd(8'h7C, v); chk("R8", "set wins over clear", v, 32'h10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule